// File: doc/BRIEF.md
# Real-Time Clock Seconds Prescaler

This block produces the once-per-second advance for a real-time clock. Each step of a 64 Hz source moves a 6-bit prescaler forward. The block issues a single-cycle `sec_pulse` at one fixed point in every 64-step cycle. That point is the transition from count 31 to count 32. A cleared prescaler therefore reaches its first second after 32 steps, and each later second follows a further 64 steps.

Two control bits change how the block behaves. `stop` holds the prescaler at zero and discards every step while it is high. When `stop` drops, the next second arrives after half of the usual count. `test_mode` moves the step source from the on-chip 64 Hz strobe to an asynchronous clock on a shared pin. The block brings that clock into the system domain and counts its rising edges. `pin_is_input` follows `test_mode`, so the pad ring can turn the pin around. Switching modes does not clear the prescaler.

Top module: `sec_prescaler`

## Requirements
- R1: After reset, `sec_pulse` and `pin_is_input` are 0 and the prescaler holds 0. The first `sec_pulse` then follows the 32nd counted step.
- R2: In steady running, exactly one `sec_pulse` is issued for every 64 counted steps. When `test_mode` is 0, a counted step is a one-cycle high on `tick_int`.
- R3: After `stop` goes from 1 to 0, the first `sec_pulse` comes on the 32nd counted step. Every later pulse comes 64 steps after the previous one.
- R4: While `stop` is 1, the prescaler is 0, steps are discarded, and `sec_pulse` stays 0 from the cycle after `stop` is sampled high.
- R5: When `test_mode` is 1, `pin_is_input` is 1 one cycle later. Each rising edge on `ext_clk` is a step, and `tick_int` has no effect.
- R6: When `test_mode` is 0, `pin_is_input` is 0 one cycle later and edges on `ext_clk` have no effect.
- R7: `sec_pulse` is never high for two cycles in a row.
- R8: Changing `test_mode` does not clear or preset the prescaler. Counting resumes from the value it held.
- R9: A `tick_int` strobe sampled in the same cycle as a change on `stop` follows the new `stop` value. After a fall of `stop` the strobe counts. After a rise of `stop` the strobe is dropped.
- R10: The prescaler changes only by +1 (wrapping 63 to 0) or by a return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_int | input | 1 | On-chip 64 Hz strobe, one cycle wide, in the clk domain |
| ext_clk | input | 1 | Asynchronous test clock taken from the shared pin |
| test_mode | input | 1 | 1 selects `ext_clk` edges as the step source |
| stop | input | 1 | 1 holds the prescaler cleared |
| sec_pulse | output | 1 | One-cycle seconds-increment strobe |
| pin_is_input | output | 1 | 1 means the shared pin is to be driven as an input |

## Verification
A counted step and a change on `stop` can land in the same cycle. That collision decides whether the boundary step is counted or dropped. The bench raises a `tick_int` strobe in the same cycle that it lowers `stop`, and again in the same cycle that it raises `stop`. It then checks the seconds pulses that follow against a model in which the new `stop` value governs the step. Random runs also flip `stop` and `test_mode` between steps, so the half-period restart and the mode-switch carry-over are exercised against the same model.

// File: rtl/secpre_pkg.sv
package secpre_pkg;
  localparam int unsigned PRE_BITS = 6;
  localparam int unsigned SYNC_DEPTH = 2;
  typedef logic [PRE_BITS-1:0] pre_cnt_t;
endpackage

// File: rtl/secpre_edge.sv
module secpre_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  // Index STAGES holds the previous synchronised value for edge detection.
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], async_in};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/secpre_src_sel.sv
module secpre_src_sel (
  input  logic clk,
  input  logic rst,
  input  logic test_mode,
  input  logic int_step,
  input  logic ext_step,
  output logic step,
  output logic dir_in
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= 1'b0;
      dir_in <= 1'b0;
    end else begin
      step   <= test_mode ? ext_step : int_step;
      dir_in <= test_mode;
    end
  end
endmodule

// File: rtl/secpre_divider.sv
module secpre_divider #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_clr,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         tick_sec
);
  // The increment fires on the move across the half-way point, so a
  // cleared counter reaches it after half a period.
  localparam logic [W-1:0] FIRE_AT = W'((1 << (W - 1)) - 1);

  always_ff @(posedge clk) begin
    if (rst || hold_clr) begin
      cnt      <= '0;
      tick_sec <= 1'b0;
    end else begin
      tick_sec <= step && (cnt == FIRE_AT);
      if (step) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler #(
  parameter int unsigned PRE_W = secpre_pkg::PRE_BITS,
  parameter int unsigned SYNC_STAGES = secpre_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_int,
  input  logic ext_clk,
  input  logic test_mode,
  input  logic stop,
  output logic sec_pulse,
  output logic pin_is_input
);
  logic             ext_rise;
  logic             step;
  logic [PRE_W-1:0] pre_cnt;

  secpre_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_clk),
    .rise     (ext_rise)
  );

  secpre_src_sel u_sel (
    .clk       (clk),
    .rst       (rst),
    .test_mode (test_mode),
    .int_step  (tick_int),
    .ext_step  (ext_rise),
    .step      (step),
    .dir_in    (pin_is_input)
  );

  secpre_divider #(.W(PRE_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .hold_clr (stop),
    .step     (step),
    .cnt      (pre_cnt),
    .tick_sec (sec_pulse)
  );
endmodule

// File: rtl/sec_prescaler_chk.sv
module sec_prescaler_chk #(
  parameter int unsigned W = 6
) (
  input logic         clk,
  input logic         rst,
  input logic         stop,
  input logic         test_mode,
  input logic         sec_pulse,
  input logic         pin_is_input,
  input logic [W-1:0] cnt
);
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |=> !sec_pulse);

  // R4
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!sec_pulse && cnt == '0));

  // R5 R6
  dir_track_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode |=> pin_is_input);

  // R6
  dir_out_chk: assert property (@(posedge clk) disable iff (rst)
    !test_mode |=> !pin_is_input);

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == '0)));
endmodule

bind sec_prescaler sec_prescaler_chk #(.W(PRE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stop         (stop),
  .test_mode    (test_mode),
  .sec_pulse    (sec_pulse),
  .pin_is_input (pin_is_input),
  .cnt          (pre_cnt)
);

// File: tb/sec_prescaler_bench.sv
`timescale 1ns/1ps
module sec_prescaler_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_int = 1'b0;
  logic ext_clk = 1'b0;
  logic test_mode = 1'b0;
  logic stop = 1'b0;
  logic sec_pulse;
  logic pin_is_input;

  int unsigned tests = 0;
  int unsigned fails = 0;
  int unsigned seen = 0;
  int unsigned wide = 0;
  int unsigned exp_sec = 0;
  int unsigned m_cnt = 0;
  logic prev_pulse = 1'b0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  sec_prescaler u_sec_prescaler (
    .clk(clk), .rst(rst), .tick_int(tick_int), .ext_clk(ext_clk),
    .test_mode(test_mode), .stop(stop), .sec_pulse(sec_pulse),
    .pin_is_input(pin_is_input)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (sec_pulse) seen++;
      if (sec_pulse && prev_pulse) wide++;
      prev_pulse <= sec_pulse;
    end
  end

  function automatic int unsigned next_cnt(input int unsigned c);
    return (c + 1) % 64;
  endfunction

  function automatic bit crosses(input int unsigned c);
    return c == 31;
  endfunction

  task automatic check(input bit ok, input string req, input int unsigned act,
                       input int unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(input bit counts);
    if (counts) begin
      if (crosses(m_cnt)) exp_sec++;
      m_cnt = next_cnt(m_cnt);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk); tick_int = 1'b1;
    @(negedge clk); tick_int = 1'b0;
    model_step(!test_mode && !stop);
    idle(5);
  endtask

  task automatic do_ext();
    @(negedge clk); ext_clk = 1'b1;
    idle(3);
    ext_clk = 1'b0;
    model_step(test_mode && !stop);
    idle(6);
  endtask

  task automatic set_stop(input bit v);
    @(negedge clk); stop = v;
    if (v) m_cnt = 0;
    idle(3);
  endtask

  task automatic set_mode(input bit v);
    @(negedge clk); test_mode = v;
    idle(3);
  endtask

  task automatic tick_with_stop(input bit v);
    @(negedge clk); stop = v; tick_int = 1'b1;
    @(negedge clk); tick_int = 1'b0;
    if (v) m_cnt = 0;
    model_step(!test_mode && !v);
    idle(5);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sec_pulse == 1'b0, "R1", sec_pulse, 0);
    check(pin_is_input == 1'b0, "R1", pin_is_input, 0);

    // R1 first second after 32 steps from reset
    for (int i = 0; i < 31; i++) do_tick();
    check(seen == 0, "R1", seen, 0);
    do_tick();
    check(seen == 1 && exp_sec == 1, "R1", seen, 1);

    // R2 steady period of 64
    for (int i = 0; i < 63; i++) do_tick();
    check(seen == 1, "R2", seen, 1);
    do_tick();
    check(seen == 2, "R2", seen, 2);

    // R4 stop discards steps
    for (int i = 0; i < 5; i++) do_tick();
    set_stop(1'b1);
    for (int i = 0; i < 40; i++) do_tick();
    check(seen == 2, "R4", seen, 2);
    // R3 half period after release
    set_stop(1'b0);
    for (int i = 0; i < 31; i++) do_tick();
    check(seen == 2, "R3", seen, 2);
    do_tick();
    check(seen == 3, "R3", seen, 3);

    // R5 test mode: direction and source
    set_stop(1'b1);
    set_mode(1'b1);
    check(pin_is_input == 1'b1, "R5", pin_is_input, 1);
    set_stop(1'b0);
    for (int i = 0; i < 40; i++) do_tick();
    check(seen == 3, "R5", seen, 3);
    for (int i = 0; i < 31; i++) do_ext();
    check(seen == 3, "R5", seen, 3);
    do_ext();
    check(seen == 4, "R5", seen, 4);

    // R6 normal mode ignores ext_clk
    set_stop(1'b1);
    set_stop(1'b0);
    set_mode(1'b0);
    check(pin_is_input == 1'b0, "R6", pin_is_input, 0);
    for (int i = 0; i < 40; i++) do_ext();
    check(seen == 4, "R6", seen, 4);

    // R8 mode change keeps count: 20 ticks then 12 edges
    for (int i = 0; i < 20; i++) do_tick();
    set_mode(1'b1);
    for (int i = 0; i < 11; i++) do_ext();
    check(seen == 4, "R8", seen, 4);
    do_ext();
    check(seen == 5, "R8", seen, 5);
    set_mode(1'b0);

    // R9 strobe in same cycle as stop fall: counted
    set_stop(1'b1);
    tick_with_stop(1'b0);
    for (int i = 0; i < 30; i++) do_tick();
    check(seen == 5, "R9", seen, 5);
    do_tick();
    check(seen == 6, "R9", seen, 6);
    // R9 strobe in same cycle as stop rise: dropped
    for (int i = 0; i < 31; i++) do_tick();
    tick_with_stop(1'b1);
    set_stop(1'b0);
    check(seen == 6, "R9", seen, 6);
    for (int i = 0; i < 32; i++) do_tick();
    check(seen == 7, "R9", seen, 7);

    // Random mix checked against the model (R2 R3 R4 R5 R6 R8)
    for (int i = 0; i < 500; i++) begin
      int unsigned r = $urandom_range(0, 99);
      if (r < 50) do_tick();
      else if (r < 85) do_ext();
      else if (r < 93) set_stop(!stop);
      else set_mode(!test_mode);
      if (i % 25 == 24) check(seen == exp_sec, "R2", seen, exp_sec);
    end
    check(seen == exp_sec, "R3", seen, exp_sec);

    // R7 pulse width
    check(wide == 0, "R7", wide, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule